// File: doc/BRIEF.md
# Wear-Levelling Block Allocator

This block hands out free flash blocks to firmware while keeping erase wear even across the whole array. It holds a saturating erase counter and a spare/in-use flag for every block. All spare blocks form a single shared pool. A background scanner walks the table one entry per clock. At the end of each pass it publishes the index of the in-use block with the lowest erase count. That block is the static block, holding cold data that is rarely rewritten.

Firmware asks for a block over a valid/ready handshake. The controller takes the lowest-indexed spare block and checks its erase count against a programmable limit. If the count is at or below the limit, that block is granted. If the count is above the limit and a static block is known, the controller raises a swap command instead. The command asks the data mover to copy the static block's contents into the worn block. Once the mover acknowledges, the worn block is marked in use and the static block is granted to the requester. An erase-done notification bumps a block's counter and returns the block to the pool.

The controller runs through four states: IDLE, PICK, SWAP and GRANT. Its transitions are:
- accept: IDLE to PICK, when a request is taken.
- empty: PICK to GRANT, when the pool has no spare block.
- plain: PICK to GRANT, when no swap is needed.
- over-wear: PICK to SWAP, when the picked block is too worn and a static block can take its place.
- hold: SWAP to SWAP, while no acknowledge has arrived.
- ack: SWAP to GRANT, when the mover acknowledges.
- done: GRANT to IDLE.

Top module: `wear_alloc`

## Requirements
- R1: After reset every block is spare with an erase count of zero, no static block is known, `req_ready` is 1 and neither `gnt_valid` nor `swap_valid` is asserted.
- R2: An erase-done for block b adds one to b's count and marks b spare. If the same block is cleared by the controller in that cycle, the erase wins.
- R3: Erase counts saturate at 2^CNT_W-1 and never wrap. A block erased more times than that still compares as maximally worn.
- R4: A request accepted at a clock edge is answered by a one-cycle `gnt_valid`, two edges later when no swap is involved. The granted block is the lowest-indexed spare block, and that block becomes in use.
- R5: When the picked block's count is strictly greater than `wear_limit`, a static block is known and that static block is in use, `swap_valid` rises. It carries `swap_src` = static block and `swap_dst` = picked block, and all three hold steady until `swap_ack`.
- R6: On `swap_ack`, the worn block becomes in use and the next cycle grants the former static block. The static block is then unknown until the scanner's next pass ends.
- R7: `req_ready` is high only in IDLE. No grant is issued while a swap waits for acknowledgement.
- R8: A request with no spare block answers with `gnt_valid` and `gnt_empty` = 1 and `gnt_blk` = 0, and changes no block's state.
- R9: The scanner examines one index per clock in ascending order and keeps the in-use block with the smallest count, ties going to the lower index. After examining the last index it publishes that block, or "none" if every block is spare.
- R10: A picked block whose count equals `wear_limit` is granted plainly, without a swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Firmware asks for a free block |
| req_ready | output | 1 | Controller can take a request |
| gnt_valid | output | 1 | One-cycle answer to a request |
| gnt_empty | output | 1 | Answer is a refusal: pool empty |
| gnt_blk | output | IDX_W | Granted block index |
| wear_limit | input | CNT_W | Over-wear threshold |
| erase_valid | input | 1 | A block erase finished |
| erase_blk | input | IDX_W | Index of the erased block |
| swap_valid | output | 1 | Swap command pending |
| swap_src | output | IDX_W | Static block whose data moves |
| swap_dst | output | IDX_W | Worn block receiving the data |
| swap_ack | input | 1 | Data mover accepted the swap |

## Verification
The bench drives a block past its counter ceiling. A wrapping counter would read as fresh and the expected swap would never appear. It sets the limit equal to a block's count; a design comparing with "greater or equal" would start a swap where a plain grant is due. It builds distinct and tied counts among in-use blocks, so a scanner that chose the wrong minimum, broke ties upward or counted spare blocks would name the wrong `swap_src`. It also drains the pool, where a design without the refusal path would grant a block that is already in use. A long mixed run of requests, erases and late acknowledgements then catches grants leaking out during a pending swap and a static pointer that outlives a swap.

// File: rtl/wal_pkg.sv
package wal_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PICK  = 2'd1,
        ST_SWAP  = 2'd2,
        ST_GRANT = 2'd3
    } wal_state_e;
endpackage

// File: rtl/wal_wear_table.sv
// Per-block saturating erase counter and spare flag.
module wal_wear_table #(
    parameter int NB = 16,
    parameter int CW = 8,
    parameter int IW = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ers_en,
    input  logic [IW-1:0]          ers_idx,
    input  logic                   clr_a_en,
    input  logic [IW-1:0]          clr_a_idx,
    input  logic                   clr_b_en,
    input  logic [IW-1:0]          clr_b_idx,
    output logic [NB-1:0][CW-1:0]  cnt_o,
    output logic [NB-1:0]          pool_o
);
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    for (genvar g = 0; g < NB; g++) begin : g_blk
        logic hit_e, hit_a, hit_b;
        assign hit_e = ers_en   && (ers_idx   == IW'(g));
        assign hit_a = clr_a_en && (clr_a_idx == IW'(g));
        assign hit_b = clr_b_en && (clr_b_idx == IW'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_o[g]  <= '0;
                pool_o[g] <= 1'b1;
            end else begin
                if (hit_a || hit_b) begin
                    pool_o[g] <= 1'b0;
                end
                if (hit_e) begin
                    pool_o[g] <= 1'b1;
                    if (cnt_o[g] != CNT_MAX) begin
                        cnt_o[g] <= cnt_o[g] + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/wal_pool_pick.sv
// Lowest-index spare block finder.
module wal_pool_pick #(
    parameter int NB = 16,
    parameter int IW = 4
) (
    input  logic [NB-1:0] pool,
    output logic          any_spare,
    output logic [IW-1:0] pick_idx
);
    always_comb begin
        pick_idx = '0;
        for (int i = NB - 1; i >= 0; i--) begin
            if (pool[i]) begin
                pick_idx = IW'(i);
            end
        end
    end

    assign any_spare = |pool;
endmodule

// File: rtl/wal_static_scan.sv
// Walks the table one entry per clock, tracking the coldest in-use block.
module wal_static_scan #(
    parameter int NB = 16,
    parameter int CW = 8,
    parameter int IW = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NB-1:0][CW-1:0]  cnt,
    input  logic [NB-1:0]          pool,
    input  logic                   kill,
    output logic [IW-1:0]          st_idx,
    output logic                   st_vld
);
    localparam logic [IW-1:0] LAST = IW'(NB - 1);

    logic [IW-1:0] scan_idx;
    logic [IW-1:0] best_idx;
    logic [CW-1:0] best_cnt;
    logic          best_hit;
    logic          cand;
    logic          at_end;

    assign cand   = !pool[scan_idx] && (!best_hit || (cnt[scan_idx] < best_cnt));
    assign at_end = (scan_idx == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scan_idx <= '0;
            best_idx <= '0;
            best_cnt <= '0;
            best_hit <= 1'b0;
            st_idx   <= '0;
            st_vld   <= 1'b0;
        end else begin
            if (at_end) begin
                scan_idx <= '0;
                best_hit <= 1'b0;
                st_idx   <= cand ? scan_idx : best_idx;
                st_vld   <= cand || best_hit;
            end else begin
                scan_idx <= scan_idx + 1'b1;
                if (cand) begin
                    best_idx <= scan_idx;
                    best_cnt <= cnt[scan_idx];
                    best_hit <= 1'b1;
                end
            end
            if (kill) begin
                st_vld <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/wal_ctrl.sv
// Allocation state machine: IDLE -> PICK -> (SWAP) -> GRANT -> IDLE.
module wal_ctrl
    import wal_pkg::*;
#(
    parameter int CW = 8,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          swap_ack,
    input  logic [CW-1:0] wear_limit,
    input  logic          any_spare,
    input  logic [IW-1:0] pick_idx,
    input  logic [CW-1:0] pick_cnt,
    input  logic [IW-1:0] st_idx,
    input  logic          st_vld,
    input  logic          st_in_pool,
    output logic          req_ready,
    output logic          gnt_valid,
    output logic          gnt_empty,
    output logic [IW-1:0] gnt_blk,
    output logic          swap_valid,
    output logic [IW-1:0] swap_src,
    output logic [IW-1:0] swap_dst,
    output logic          clr_a_en,
    output logic [IW-1:0] clr_a_idx,
    output logic          clr_b_en,
    output logic [IW-1:0] clr_b_idx,
    output logic          scan_kill
);
    wal_state_e    state, state_nx;
    logic [IW-1:0] blk_q, src_q, dst_q;
    logic          empty_q;
    logic          swap_ok;

    assign swap_ok = (pick_cnt > wear_limit) && st_vld && !st_in_pool;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (req_valid) state_nx = ST_PICK;
            ST_PICK:  state_nx = (any_spare && swap_ok) ? ST_SWAP : ST_GRANT;
            ST_SWAP:  if (swap_ack) state_nx = ST_GRANT;
            ST_GRANT: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            blk_q   <= '0;
            src_q   <= '0;
            dst_q   <= '0;
            empty_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_PICK) begin
                if (!any_spare) begin
                    empty_q <= 1'b1;
                    blk_q   <= '0;
                end else if (swap_ok) begin
                    src_q <= st_idx;
                    dst_q <= pick_idx;
                end else begin
                    empty_q <= 1'b0;
                    blk_q   <= pick_idx;
                end
            end else if ((state == ST_SWAP) && swap_ack) begin
                empty_q <= 1'b0;
                blk_q   <= src_q;
            end
        end
    end

    always_comb begin
        req_ready  = 1'b0;
        gnt_valid  = 1'b0;
        swap_valid = 1'b0;
        clr_a_en   = 1'b0;
        clr_a_idx  = pick_idx;
        clr_b_en   = 1'b0;
        clr_b_idx  = src_q;
        scan_kill  = 1'b0;
        unique case (state)
            ST_IDLE:  req_ready = 1'b1;
            ST_PICK:  clr_a_en = any_spare && !swap_ok;
            ST_SWAP: begin
                swap_valid = 1'b1;
                clr_a_idx  = dst_q;
                clr_a_en   = swap_ack;
                clr_b_en   = swap_ack;
                scan_kill  = swap_ack;
            end
            ST_GRANT: gnt_valid = 1'b1;
            default:  req_ready = 1'b0;
        endcase
    end

    assign gnt_empty = empty_q;
    assign gnt_blk   = blk_q;
    assign swap_src  = src_q;
    assign swap_dst  = dst_q;
endmodule

// File: rtl/wear_alloc.sv
module wear_alloc #(
    parameter int NUM_BLOCKS = 16,
    parameter int CNT_W      = 8,
    parameter int IDX_W      = $clog2(NUM_BLOCKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    output logic             gnt_valid,
    output logic             gnt_empty,
    output logic [IDX_W-1:0] gnt_blk,
    input  logic [CNT_W-1:0] wear_limit,
    input  logic             erase_valid,
    input  logic [IDX_W-1:0] erase_blk,
    output logic             swap_valid,
    output logic [IDX_W-1:0] swap_src,
    output logic [IDX_W-1:0] swap_dst,
    input  logic             swap_ack
);
    logic [NUM_BLOCKS-1:0][CNT_W-1:0] cnt_w;
    logic [NUM_BLOCKS-1:0]            pool_w;
    logic                             any_spare;
    logic [IDX_W-1:0]                 pick_idx;
    logic [IDX_W-1:0]                 st_idx;
    logic                             st_vld;
    logic                             clr_a_en, clr_b_en, scan_kill;
    logic [IDX_W-1:0]                 clr_a_idx, clr_b_idx;

    wal_wear_table #(.NB(NUM_BLOCKS), .CW(CNT_W), .IW(IDX_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .ers_en(erase_valid), .ers_idx(erase_blk),
        .clr_a_en(clr_a_en), .clr_a_idx(clr_a_idx),
        .clr_b_en(clr_b_en), .clr_b_idx(clr_b_idx),
        .cnt_o(cnt_w), .pool_o(pool_w)
    );

    wal_pool_pick #(.NB(NUM_BLOCKS), .IW(IDX_W)) u_pick (
        .pool(pool_w), .any_spare(any_spare), .pick_idx(pick_idx)
    );

    wal_static_scan #(.NB(NUM_BLOCKS), .CW(CNT_W), .IW(IDX_W)) u_scan (
        .clk(clk), .rst_n(rst_n), .cnt(cnt_w), .pool(pool_w),
        .kill(scan_kill), .st_idx(st_idx), .st_vld(st_vld)
    );

    wal_ctrl #(.CW(CNT_W), .IW(IDX_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .swap_ack(swap_ack), .wear_limit(wear_limit),
        .any_spare(any_spare), .pick_idx(pick_idx), .pick_cnt(cnt_w[pick_idx]),
        .st_idx(st_idx), .st_vld(st_vld), .st_in_pool(pool_w[st_idx]),
        .req_ready(req_ready), .gnt_valid(gnt_valid), .gnt_empty(gnt_empty),
        .gnt_blk(gnt_blk), .swap_valid(swap_valid), .swap_src(swap_src),
        .swap_dst(swap_dst), .clr_a_en(clr_a_en), .clr_a_idx(clr_a_idx),
        .clr_b_en(clr_b_en), .clr_b_idx(clr_b_idx), .scan_kill(scan_kill)
    );
endmodule

// File: rtl/wear_alloc_chk.sv
module wear_alloc_chk #(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             gnt_valid,
    input logic             swap_valid,
    input logic             swap_ack,
    input logic [IDX_W-1:0] swap_src,
    input logic [IDX_W-1:0] swap_dst
);
    // R5: pending swap command holds its fields until acknowledged
    assert_swap_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_valid && !swap_ack) |=> (swap_valid && $stable(swap_src) && $stable(swap_dst)));

    // R5: the static and worn blocks of a swap are distinct
    assert_swap_distinct_R5: assert property (@(posedge clk) disable iff (!rst_n)
        swap_valid |-> (swap_src != swap_dst));

    // R7: never a grant while a swap waits
    assert_no_grant_in_swap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(gnt_valid && swap_valid));

    // R7: a taken request drops ready on the next cycle
    assert_ready_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R7: grant cycle is not a ready cycle
    assert_grant_not_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> !req_ready);

    // R4: a grant lasts exactly one cycle
    assert_grant_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |=> !gnt_valid);

    // R6: acknowledged swap is followed by a grant
    assert_ack_grants_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_valid && swap_ack) |=> gnt_valid);
endmodule

bind wear_alloc wear_alloc_chk #(.IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .gnt_valid(gnt_valid), .swap_valid(swap_valid), .swap_ack(swap_ack),
    .swap_src(swap_src), .swap_dst(swap_dst)
);

// File: tb/wear_alloc_test.sv
`timescale 1ns/100ps
module wear_alloc_test;
    localparam int N  = 8;
    localparam int CW = 4;
    localparam int IW = 3;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          gnt_valid;
    logic          gnt_empty;
    logic [IW-1:0] gnt_blk;
    logic [CW-1:0] wear_limit = '1;
    logic          erase_valid = 1'b0;
    logic [IW-1:0] erase_blk = '0;
    logic          swap_valid;
    logic [IW-1:0] swap_src;
    logic [IW-1:0] swap_dst;
    logic          swap_ack = 1'b0;

    always #2.5 clk = ~clk;

    wear_alloc #(.NUM_BLOCKS(N), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .gnt_valid(gnt_valid), .gnt_empty(gnt_empty), .gnt_blk(gnt_blk),
        .wear_limit(wear_limit), .erase_valid(erase_valid), .erase_blk(erase_blk),
        .swap_valid(swap_valid), .swap_src(swap_src), .swap_dst(swap_dst),
        .swap_ack(swap_ack)
    );

    int  n_chk = 0;
    int  n_fail = 0;
    int  cyc = 0;
    bit  done = 0;

    // reference model state
    int  m_cnt[N];
    bit  m_pool[N];
    int  m_st, m_gb, m_ss, m_sd, m_sptr, m_scan, m_best, m_bestc;
    bit  m_ge, m_svld;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic model_init();
        for (int i = 0; i < N; i++) begin m_cnt[i] = 0; m_pool[i] = 1; end
        m_st = 0; m_gb = 0; m_ss = 0; m_sd = 0; m_sptr = 0;
        m_scan = 0; m_best = -1; m_bestc = 0; m_ge = 0; m_svld = 0;
    endtask

    task automatic compare();
        chk(req_ready == (m_st == 0), "R7", "req_ready", int'(req_ready), int'(m_st == 0));
        chk(gnt_valid == (m_st == 3), "R4", "gnt_valid", int'(gnt_valid), int'(m_st == 3));
        chk(swap_valid == (m_st == 2), "R5/R6/R9", "swap_valid", int'(swap_valid), int'(m_st == 2));
        if (m_st == 3) begin
            chk(int'(gnt_blk) == m_gb, "R4", "gnt_blk", int'(gnt_blk), m_gb);
            chk(gnt_empty == m_ge, "R8", "gnt_empty", int'(gnt_empty), int'(m_ge));
        end
        if (m_st == 2) begin
            chk(int'(swap_src) == m_ss, "R9", "swap_src", int'(swap_src), m_ss);
            chk(int'(swap_dst) == m_sd, "R5", "swap_dst", int'(swap_dst), m_sd);
        end
    endtask

    // advance model by one clock edge using pre-edge state
    task automatic model_step(input bit rv, input bit ev, input int eb, input bit ak);
        int  nst = m_st;
        int  ca = -1, cb = -1;
        bit  kill = 0;
        int  sel = -1;
        case (m_st)
            0: if (rv) nst = 1;
            1: begin
                for (int i = N - 1; i >= 0; i--) if (m_pool[i]) sel = i;
                if (sel < 0) begin
                    m_ge = 1; m_gb = 0; nst = 3;
                end else if (m_cnt[sel] > int'(wear_limit) && m_svld && !m_pool[m_sptr]) begin
                    m_ss = m_sptr; m_sd = sel; nst = 2;
                end else begin
                    ca = sel; m_ge = 0; m_gb = sel; nst = 3;
                end
            end
            2: if (ak) begin
                ca = m_sd; cb = m_ss; m_gb = m_ss; m_ge = 0; kill = 1; nst = 3;
            end
            default: nst = 0;
        endcase
        // scanner
        if (!m_pool[m_scan] && (m_best < 0 || m_cnt[m_scan] < m_bestc)) begin
            m_best = m_scan; m_bestc = m_cnt[m_scan];
        end
        if (m_scan == N - 1) begin
            if (m_best >= 0) m_sptr = m_best;
            m_svld = (m_best >= 0);
            m_best = -1; m_scan = 0;
        end else begin
            m_scan++;
        end
        if (kill) m_svld = 0;
        if (ca >= 0) m_pool[ca] = 0;
        if (cb >= 0) m_pool[cb] = 0;
        if (ev) begin
            m_pool[eb] = 1;
            if (m_cnt[eb] < CMAX) m_cnt[eb]++;
        end
        m_st = nst;
    endtask

    task automatic tick(input bit rv, input bit ev, input int eb, input bit ak);
        req_valid = rv; erase_valid = ev; erase_blk = IW'(eb); swap_ack = ak;
        model_step(rv, ev, eb, ak);
        @(negedge clk);
        cyc++;
        compare();
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) tick(0, 0, 0, 0);
    endtask

    task automatic erase_n(input int b, input int n);
        for (int k = 0; k < n; k++) tick(0, 1, b, 0);
    endtask

    task automatic req_wait(output int blk, output bit emp, output bit sw,
                            output int s, output int d);
        sw = 0; s = -1; d = -1; blk = -1; emp = 0;
        tick(1, 0, 0, 0);
        for (int k = 0; k < 12; k++) begin
            bit ak;
            ak = swap_valid;
            if (swap_valid) begin sw = 1; s = int'(swap_src); d = int'(swap_dst); end
            if (gnt_valid) begin blk = int'(gnt_blk); emp = gnt_empty; break; end
            tick(0, 0, 0, ak);
        end
        tick(0, 0, 0, 0);
    endtask

    task automatic do_reset();
        rst_n = 0; req_valid = 0; erase_valid = 0; swap_ack = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        model_init();
        chk(req_ready == 1, "R1", "reset req_ready", int'(req_ready), 1);
        chk(gnt_valid == 0, "R1", "reset gnt_valid", int'(gnt_valid), 0);
        chk(swap_valid == 0, "R1", "reset swap_valid", int'(swap_valid), 0);
    endtask

    always @(posedge clk) begin
        if (cyc > 100000 && !done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int  blk, s, d;
        bit  emp, sw;

        do_reset();
        wear_limit = 4'd15;

        // R4: lowest-index spare handed out in order
        for (int i = 0; i < N; i++) begin
            req_wait(blk, emp, sw, s, d);
            chk(blk == i && !emp && !sw, "R4", "in-order grant", blk, i);
        end
        // R8: empty pool refuses
        req_wait(blk, emp, sw, s, d);
        chk(emp == 1 && blk == 0, "R8", "empty refusal", int'(emp), 1);
        // R2: erase returns block to pool, refusal took nothing
        erase_n(5, 1);
        req_wait(blk, emp, sw, s, d);
        chk(blk == 5 && !emp, "R2", "erased block regranted", blk, 5);

        // R3: saturated count still over limit 14
        wear_limit = 4'd14;
        erase_n(5, 20);
        idle(20);
        req_wait(blk, emp, sw, s, d);
        chk(sw == 1 && d == 5, "R3", "saturated count triggers swap dst", d, 5);
        chk(s == 0, "R5", "swap src is coldest in-use block", s, 0);
        chk(blk == 0, "R6", "grant after ack is static block", blk, 0);

        // R10: count equal to limit -> plain grant
        erase_n(6, 5);
        wear_limit = 4'd5;
        idle(20);
        req_wait(blk, emp, sw, s, d);
        chk(sw == 0 && blk == 6, "R10", "equal count plain grant", blk, 6);
        erase_n(6, 1);
        idle(20);
        req_wait(blk, emp, sw, s, d);
        chk(sw == 1 && d == 6, "R5", "one above limit swaps", d, 6);
        chk(blk == s, "R6", "granted block equals swap src", blk, s);

        // R9: scanner minimum among distinct and tied counts
        do_reset();
        wear_limit = 4'd15;
        for (int i = 0; i < N; i++) req_wait(blk, emp, sw, s, d);
        erase_n(0, 3); erase_n(1, 2); erase_n(2, 1);
        for (int b = 3; b < N; b++) erase_n(b, 4);
        for (int i = 0; i < N; i++) req_wait(blk, emp, sw, s, d);
        erase_n(7, 3);
        wear_limit = 4'd5;
        idle(20);
        req_wait(blk, emp, sw, s, d);
        chk(sw == 1 && s == 2, "R9", "coldest in-use block chosen", s, 2);
        chk(d == 7, "R5", "worn block is dst", d, 7);

        // mixed traffic against the model
        do_reset();
        for (int k = 0; k < 4000; k++) begin
            int sel_lim;
            if (k % 250 == 0) begin
                sel_lim = $urandom_range(0, 3);
                wear_limit = (sel_lim == 0) ? 4'd1 : (sel_lim == 1) ? 4'd3 :
                             (sel_lim == 2) ? 4'd6 : 4'd15;
            end
            tick($urandom_range(0, 9) < 4, $urandom_range(0, 9) < 3,
                 $urandom_range(0, N - 1), $urandom_range(0, 1) == 1);
        end
        idle(4);

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule